// File: doc/BRIEF.md
# Single-Bus Multicycle Processor Core

This block is a small 32-bit processor that moves every value over one shared internal bus. The register file, the ALU, the program counter, the offset extender and a word memory each place a value on the bus when their drive enable is set, and at most one of them does so in any cycle. The A and B operand latches, the PC, the instruction register and a memory address register take their value from the bus. A state-machine controller runs three fetch cycles and then an execute sequence chosen by the opcode, so each instruction takes between five and nine clock cycles.

The core knows ten operations: register add and nand, add-immediate, word load and store, branch-if-equal, signed branch-if-greater, jump-and-link through a register, a PC-relative address computation and halt. The internal memory holds both code and data and is addressed by word. A testbench or a loader writes it through a load port while reset is held. After reset is released the core fetches from word 0 and runs until it halts. Two debug read ports let the surrounding logic read any register and any memory word at any time.

Top module: `sbus_core`

## Requirements
- R1: While rst_n is low, halted is 0 and all sixteen registers read 0. After rst_n is released, the first instruction is fetched from word 0.
- R2: Instruction fields are: opcode in bits [31:28], X in [27:24], Y in [23:20], Z in [3:0], and a signed 20-bit offset in [19:0]. add (0000) writes Y+Z to X. nand (0001) writes ~(Y&Z) to X. addi (0010) writes Y+sext(offset) to X. Each of these takes 6 cycles.
- R3: lw (0011) loads X from memory word Y+sext(offset). sw (0100) stores X to memory word Y+sext(offset). Each takes 7 cycles, and a negative offset is sign-extended.
- R4: beq (0101) branches when X equals Y. bgt (1000) branches when X is greater than Y as signed numbers. A taken branch goes to the branch address+1+sext(offset) and takes 9 cycles. A branch that is not taken takes 6 cycles.
- R5: jalr (0110) writes the jalr address+1 into Y and then continues at the value of X, all in 5 cycles. When X and Y name the same register, execution continues at the jalr address+1.
- R6: lea (1001) writes the lea address+1+sext(offset) to X and takes 6 cycles.
- R7: Register 0 always reads 0, and writes to it have no effect.
- R8: halt (0111) raises halted 3 cycles after its fetch begins. After that, halted stays high and neither the registers nor the memory change again until reset.
- R9: At most one source drives the internal bus in any cycle.
- R10: Opcodes 1010 through 1111 behave like halt.
- R11: Every fetch advances the PC by exactly one before the execute cycles begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Write enable for the memory load port |
| ld_addr | input | 8 | Word address for the memory load port |
| ld_data | input | 32 | Data word for the memory load port |
| dbg_reg_sel | input | 4 | Register index for the debug read |
| dbg_mem_addr | input | 8 | Memory word address for the debug read |
| halted | output | 1 | High once a halt-class opcode has executed |
| dbg_reg_data | output | 32 | Current value of the selected register |
| dbg_mem_data | output | 32 | Current value of the addressed memory word |

## Verification
Every instruction class has a fixed cycle cost: 6 for ALU operations, addi, lea and untaken branches, 7 for loads and stores, 9 for taken branches, 5 for jalr and 3 for halt. The bench adds these costs along the path the test program takes. It counts rising edges from the first active edge after reset release, and it expects halted to read high at the falling edge after exactly that edge and not one earlier. Register and memory results can only be trusted once the core has halted, so the scoreboard is drained after halt through the debug ports. It is drained again twenty cycles later, which shows that the halted core changes nothing.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  localparam int WORD_W = 32;
  localparam int RIDX_W = 4;
  localparam int OFF_W  = 20;

  localparam logic [3:0] OPC_ADD  = 4'd0;
  localparam logic [3:0] OPC_NAND = 4'd1;
  localparam logic [3:0] OPC_ADDI = 4'd2;
  localparam logic [3:0] OPC_LW   = 4'd3;
  localparam logic [3:0] OPC_SW   = 4'd4;
  localparam logic [3:0] OPC_BEQ  = 4'd5;
  localparam logic [3:0] OPC_JALR = 4'd6;
  localparam logic [3:0] OPC_HALT = 4'd7;
  localparam logic [3:0] OPC_BGT  = 4'd8;
  localparam logic [3:0] OPC_LEA  = 4'd9;

  typedef enum logic [1:0] {ALU_ADD, ALU_NAND, ALU_INC} alu_fn_e;

  typedef enum logic [1:0] {RS_X, RS_Y, RS_Z} rsel_e;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_E0, S_E1, S_E2, S_E3, S_B0, S_B1, S_B2, S_HALT
  } state_e;

  typedef struct packed {
    logic    dr_reg;
    logic    dr_alu;
    logic    dr_off;
    logic    dr_pc;
    logic    dr_mem;
    logic    ld_a;
    logic    ld_b;
    logic    ld_pc;
    logic    ld_ir;
    logic    ld_mar;
    logic    wr_reg;
    logic    wr_mem;
    rsel_e   rsel;
    alu_fn_e alu_fn;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] sext_off(input logic [OFF_W-1:0] off);
    return {{(WORD_W-OFF_W){off[OFF_W-1]}}, off};
  endfunction

  function automatic logic [WORD_W-1:0] alu_eval(input alu_fn_e fn,
                                                 input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    case (fn)
      ALU_NAND: return ~(a & b);
      ALU_INC:  return a + 1;
      default:  return a + b;
    endcase
  endfunction

  function automatic logic halts_core(input logic [3:0] op);
    return (op == OPC_HALT) || (op > OPC_LEA);
  endfunction

endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile
  import sbus_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int W     = WORD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NREGS)-1:0] rd_idx,
  output logic [W-1:0]             rd_data,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_idx,
  input  logic [W-1:0]             wr_data,
  input  logic [$clog2(NREGS)-1:0] dbg_idx,
  output logic [W-1:0]             dbg_data
);
  localparam int IW = $clog2(NREGS);

  logic [W-1:0] regs [NREGS];
  logic         wr_zero_evt;

  assign wr_zero_evt = wr_en && (wr_idx == IW'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en && !wr_zero_evt) begin
      regs[wr_idx] <= wr_data;
    end
  end

  assign rd_data  = (rd_idx  == IW'(0)) ? '0 : regs[rd_idx];
  assign dbg_data = (dbg_idx == IW'(0)) ? '0 : regs[dbg_idx];

  // A write aimed at register 0 leaves its stored value at zero
  assert_r0_ignores_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_zero_evt |=> (regs[0] == '0));

endmodule

// File: rtl/sbus_mem.sv
module sbus_mem
  import sbus_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int W     = WORD_W
) (
  input  logic                     clk,
  input  logic                     ld_we,
  input  logic [$clog2(WORDS)-1:0] ld_addr,
  input  logic [W-1:0]             ld_data,
  input  logic [$clog2(WORDS)-1:0] addr,
  input  logic                     we,
  input  logic [W-1:0]             wdata,
  output logic [W-1:0]             rdata,
  input  logic [$clog2(WORDS)-1:0] dbg_addr,
  output logic [W-1:0]             dbg_data
);
  logic [W-1:0] words [WORDS];

  always_ff @(posedge clk) begin
    if (ld_we)   words[ld_addr] <= ld_data;
    else if (we) words[addr]    <= wdata;
  end

  assign rdata    = words[addr];
  assign dbg_data = words[dbg_addr];

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  assign y = alu_eval(fn, a, b);
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opcode,
  input  logic       a_eq_b,
  input  logic       a_gt_b,
  output ctrl_t      ctl,
  output state_e     state,
  output logic       halted
);
  state_e state_q, state_d;
  logic   br_taken;

  assign br_taken = (opcode == OPC_BEQ) ? a_eq_b : a_gt_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_F0;
    else        state_q <= state_d;
  end

  always_comb begin
    ctl     = '0;
    state_d = state_q;
    case (state_q)
      S_F0: begin
        ctl.dr_pc = 1'b1; ctl.ld_mar = 1'b1; ctl.ld_a = 1'b1;
        state_d = S_F1;
      end
      S_F1: begin
        ctl.dr_mem = 1'b1; ctl.ld_ir = 1'b1;
        state_d = S_F2;
      end
      S_F2: begin
        ctl.alu_fn = ALU_INC; ctl.dr_alu = 1'b1; ctl.ld_pc = 1'b1;
        state_d = halts_core(opcode) ? S_HALT : S_E0;
      end
      S_E0: begin
        state_d = S_E1;
        case (opcode)
          OPC_BEQ, OPC_BGT: begin
            ctl.dr_reg = 1'b1; ctl.rsel = RS_X; ctl.ld_a = 1'b1;
          end
          OPC_JALR: begin
            ctl.dr_pc = 1'b1; ctl.rsel = RS_Y; ctl.wr_reg = 1'b1;
          end
          OPC_LEA: begin
            ctl.dr_pc = 1'b1; ctl.ld_a = 1'b1;
          end
          default: begin
            ctl.dr_reg = 1'b1; ctl.rsel = RS_Y; ctl.ld_a = 1'b1;
          end
        endcase
      end
      S_E1: begin
        state_d = S_E2;
        case (opcode)
          OPC_ADD, OPC_NAND: begin
            ctl.dr_reg = 1'b1; ctl.rsel = RS_Z; ctl.ld_b = 1'b1;
          end
          OPC_BEQ, OPC_BGT: begin
            ctl.dr_reg = 1'b1; ctl.rsel = RS_Y; ctl.ld_b = 1'b1;
          end
          OPC_JALR: begin
            ctl.dr_reg = 1'b1; ctl.rsel = RS_X; ctl.ld_pc = 1'b1;
            state_d = S_F0;
          end
          default: begin
            ctl.dr_off = 1'b1; ctl.ld_b = 1'b1;
          end
        endcase
      end
      S_E2: begin
        state_d = S_F0;
        case (opcode)
          OPC_LW, OPC_SW: begin
            ctl.alu_fn = ALU_ADD; ctl.dr_alu = 1'b1; ctl.ld_mar = 1'b1;
            state_d = S_E3;
          end
          OPC_BEQ, OPC_BGT: begin
            state_d = br_taken ? S_B0 : S_F0;
          end
          OPC_NAND: begin
            ctl.alu_fn = ALU_NAND; ctl.dr_alu = 1'b1;
            ctl.rsel = RS_X; ctl.wr_reg = 1'b1;
          end
          default: begin
            ctl.alu_fn = ALU_ADD; ctl.dr_alu = 1'b1;
            ctl.rsel = RS_X; ctl.wr_reg = 1'b1;
          end
        endcase
      end
      S_E3: begin
        state_d = S_F0;
        ctl.rsel = RS_X;
        if (opcode == OPC_LW) begin
          ctl.dr_mem = 1'b1; ctl.wr_reg = 1'b1;
        end else begin
          ctl.dr_reg = 1'b1; ctl.wr_mem = 1'b1;
        end
      end
      S_B0: begin
        ctl.dr_pc = 1'b1; ctl.ld_a = 1'b1;
        state_d = S_B1;
      end
      S_B1: begin
        ctl.dr_off = 1'b1; ctl.ld_b = 1'b1;
        state_d = S_B2;
      end
      S_B2: begin
        ctl.alu_fn = ALU_ADD; ctl.dr_alu = 1'b1; ctl.ld_pc = 1'b1;
        state_d = S_F0;
      end
      default: state_d = S_HALT;
    endcase
  end

  assign state  = state_q;
  assign halted = (state_q == S_HALT);

  // Once stopped, the controller stays stopped until reset
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // A stopped controller issues no loads or writes
  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(ctl.wr_reg || ctl.wr_mem || ctl.ld_pc));

endmodule

// File: rtl/sbus_core.sv
module sbus_core
  import sbus_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  parameter int NREGS     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_we,
  input  logic [$clog2(MEM_WORDS)-1:0] ld_addr,
  input  logic [WORD_W-1:0]            ld_data,
  input  logic [$clog2(NREGS)-1:0]     dbg_reg_sel,
  input  logic [$clog2(MEM_WORDS)-1:0] dbg_mem_addr,
  output logic                         halted,
  output logic [WORD_W-1:0]            dbg_reg_data,
  output logic [WORD_W-1:0]            dbg_mem_data
);
  localparam int AW = $clog2(MEM_WORDS);
  localparam int IW = $clog2(NREGS);
  localparam int NDRV = 5;

  ctrl_t              ctl;
  state_e             state;
  logic [WORD_W-1:0]  bus;
  logic [WORD_W-1:0]  pc_q, a_q, b_q, ir_q, mar_q;
  logic [WORD_W-1:0]  rf_rd, alu_y, mem_rd, off_ext;
  logic [IW-1:0]      rf_idx;
  logic [NDRV-1:0]    drivers;
  logic               ev_fetch_inc, ev_br_commit;
  logic               a_eq_b, a_gt_b;
  logic [WORD_W-AW-1:0] mar_hi_unused;

  // Instruction fields
  logic [3:0]         f_op;
  logic [IW-1:0]      f_x, f_y, f_z;
  assign f_op    = ir_q[31:28];
  assign f_x     = ir_q[27:24];
  assign f_y     = ir_q[23:20];
  assign f_z     = ir_q[3:0];
  assign off_ext = sext_off(ir_q[OFF_W-1:0]);

  assign a_eq_b = (a_q == b_q);
  assign a_gt_b = ($signed(a_q) > $signed(b_q));

  always_comb begin
    case (ctl.rsel)
      RS_Y:    rf_idx = f_y;
      RS_Z:    rf_idx = f_z;
      default: rf_idx = f_x;
    endcase
  end

  sbus_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (f_op),
    .a_eq_b (a_eq_b),
    .a_gt_b (a_gt_b),
    .ctl    (ctl),
    .state  (state),
    .halted (halted)
  );

  sbus_regfile #(.NREGS(NREGS), .W(WORD_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rf_idx),
    .rd_data  (rf_rd),
    .wr_en    (ctl.wr_reg),
    .wr_idx   (rf_idx),
    .wr_data  (bus),
    .dbg_idx  (dbg_reg_sel),
    .dbg_data (dbg_reg_data)
  );

  sbus_alu #(.W(WORD_W)) u_alu (
    .fn (ctl.alu_fn),
    .a  (a_q),
    .b  (b_q),
    .y  (alu_y)
  );

  sbus_mem #(.WORDS(MEM_WORDS), .W(WORD_W)) u_mem (
    .clk      (clk),
    .ld_we    (ld_we),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .addr     (mar_q[AW-1:0]),
    .we       (ctl.wr_mem),
    .wdata    (bus),
    .rdata    (mem_rd),
    .dbg_addr (dbg_mem_addr),
    .dbg_data (dbg_mem_data)
  );

  assign mar_hi_unused = mar_q[WORD_W-1:AW];

  // Bus: AND-OR of gated sources, one enable per source
  assign drivers = {ctl.dr_reg, ctl.dr_alu, ctl.dr_off, ctl.dr_pc, ctl.dr_mem};
  assign bus = ({WORD_W{ctl.dr_reg}} & rf_rd)
             | ({WORD_W{ctl.dr_alu}} & alu_y)
             | ({WORD_W{ctl.dr_off}} & off_ext)
             | ({WORD_W{ctl.dr_pc }} & pc_q)
             | ({WORD_W{ctl.dr_mem}} & mem_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      ir_q  <= '0;
      mar_q <= '0;
    end else begin
      if (ctl.ld_pc)  pc_q  <= bus;
      if (ctl.ld_a)   a_q   <= bus;
      if (ctl.ld_b)   b_q   <= bus;
      if (ctl.ld_ir)  ir_q  <= bus;
      if (ctl.ld_mar) mar_q <= bus;
    end
  end

  assign ev_fetch_inc = (state == S_F2);
  assign ev_br_commit = (state == S_B2);

  assert_single_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drivers));

  assert_fetch_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_inc |=> (pc_q == $past(pc_q) + 1));

  assert_branch_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_br_commit |=> (pc_q == $past(pc_q) + sext_off($past(ir_q[OFF_W-1:0]))));

  assert_halt_pc_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc_q));

endmodule

// File: tb/sbus_core_test.sv
`timescale 1ns/1ps
module sbus_core_test;
  localparam int MEM_WORDS = 256;
  localparam int AW = $clog2(MEM_WORDS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [3:0]    dbg_reg_sel = '0;
  logic [AW-1:0] dbg_mem_addr = '0;
  logic          halted;
  logic [31:0]   dbg_reg_data, dbg_mem_data;

  int n_checks = 0;
  int n_fails  = 0;
  int wd_count = 0;

  typedef struct {
    bit          is_mem;
    int          idx;
    logic [31:0] val;
    string       req;
  } exp_item_t;

  exp_item_t sb_q[$];
  bit drain_req = 1'b0;

  always #2.5 clk = ~clk;

  sbus_core #(.MEM_WORDS(MEM_WORDS)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_we        (ld_we),
    .ld_addr      (ld_addr),
    .ld_data      (ld_data),
    .dbg_reg_sel  (dbg_reg_sel),
    .dbg_mem_addr (dbg_mem_addr),
    .halted       (halted),
    .dbg_reg_data (dbg_reg_data),
    .dbg_mem_data (dbg_mem_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [3:0] op, input int x,
                                      input int y, input int off);
    logic [31:0] o32;
    o32 = 32'(off);
    return {op, 4'(x), 4'(y), o32[19:0]};
  endfunction

  task automatic load_word(input int addr, input logic [31:0] data);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = AW'(addr); ld_data = data;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic push_reg(input int idx, input logic [31:0] val, input string req);
    exp_item_t it;
    it.is_mem = 1'b0; it.idx = idx; it.val = val; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic push_mem(input int idx, input logic [31:0] val, input string req);
    exp_item_t it;
    it.is_mem = 1'b1; it.idx = idx; it.val = val; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    drain_req = 1'b1;
    wait (drain_req == 1'b0);
  endtask

  // Monitor: pops expected items and compares them through the debug ports
  initial begin
    forever begin
      wait (drain_req == 1'b1);
      while (sb_q.size() > 0) begin
        exp_item_t it;
        it = sb_q.pop_front();
        @(negedge clk);
        if (it.is_mem) begin
          dbg_mem_addr = AW'(it.idx);
          #1;
          check(dbg_mem_data === it.val, it.req, dbg_mem_data, it.val);
        end else begin
          dbg_reg_sel = 4'(it.idx);
          #1;
          check(dbg_reg_data === it.val, it.req, dbg_reg_data, it.val);
        end
      end
      drain_req = 1'b0;
    end
  end

  // Count edges from the first active edge after reset until halted is seen
  task automatic run_until_halt(output int cycles);
    cycles = 0;
    @(negedge clk);
    rst_n = 1'b1;
    forever begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      if (halted || cycles > 2000) break;
    end
  endtask

  always @(posedge clk) begin
    wd_count++;
    if (wd_count > 20000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd_count);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    rst_n = 1'b0;
    // Test program, word addresses on the left
    load_word(0,  enc(4'd2, 1, 0, 5));      // addi r1,r0,5
    load_word(1,  enc(4'd2, 2, 0, -3));     // addi r2,r0,-3
    load_word(2,  enc(4'd0, 3, 1, 2));      // add r3,r1,r2
    load_word(3,  enc(4'd1, 4, 1, 2));      // nand r4,r1,r2
    load_word(4,  enc(4'd4, 1, 0, 64));     // sw r1,64(r0)
    load_word(5,  enc(4'd3, 5, 0, 64));     // lw r5,64(r0)
    load_word(6,  enc(4'd8, 2, 1, 5));      // bgt r2,r1 not taken
    load_word(7,  enc(4'd8, 1, 2, 1));      // bgt r1,r2 taken -> 9
    load_word(8,  enc(4'd2, 6, 0, 99));     // skipped
    load_word(9,  enc(4'd5, 1, 5, 1));      // beq r1,r5 taken -> 11
    load_word(10, enc(4'd2, 6, 0, 77));     // skipped
    load_word(11, enc(4'd5, 1, 2, 2));      // beq r1,r2 not taken
    load_word(12, enc(4'd9, 7, 0, 4));      // lea r7,+4 -> 17
    load_word(13, enc(4'd6, 7, 8, 0));      // jalr to r7, link r8=14
    load_word(14, enc(4'd2, 6, 0, 55));     // skipped
    load_word(15, enc(4'd7, 0, 0, 0));
    load_word(16, enc(4'd7, 0, 0, 0));
    load_word(17, enc(4'd2, 9, 0, 1));      // addi r9,r0,1
    load_word(18, enc(4'd6, 10, 10, 0));    // jalr same reg -> 19
    load_word(19, enc(4'd2, 0, 0, 7));      // addi r0,r0,7 (ignored)
    load_word(20, enc(4'd2, 11, 8, -1));    // addi r11,r8,-1 = 13
    load_word(21, enc(4'd9, 12, 0, -5));    // lea r12,-5 -> 17
    load_word(22, enc(4'd4, 11, 9, 61));    // sw r11,61(r9) -> mem[62]
    load_word(23, enc(4'd7, 0, 0, 0));      // halt

    // R1: reset state
    @(negedge clk);
    check(halted === 1'b0, "R1 halted low in reset", 32'(halted), 32'd0);
    for (int i = 0; i < 16; i++) push_reg(i, 32'd0, "R1 register zero in reset");
    drain();

    // Cycle budget: 6*4 + 7*2 + 6 + 9 + 9 + 6 + 6 + 5 + 6 + 5 + 6*3 + 7 + 3 = 118 (R2..R6, R8, R11)
    run_until_halt(cyc);
    check(cyc == 118, "R8 R11 cycles to halt", 32'(cyc), 32'd118);

    push_reg(0,  32'd0,          "R7 r0 ignores write");
    push_reg(1,  32'd5,          "R2 addi result");
    push_reg(2,  32'hFFFF_FFFD,  "R2 addi negative offset");
    push_reg(3,  32'd2,          "R2 add result");
    push_reg(4,  32'hFFFF_FFFA,  "R2 nand result");
    push_reg(5,  32'd5,          "R3 lw result");
    push_reg(6,  32'd0,          "R4 taken branches skip");
    push_reg(7,  32'd17,         "R6 lea forward");
    push_reg(8,  32'd14,         "R5 jalr link");
    push_reg(9,  32'd1,          "R5 jalr target reached");
    push_reg(10, 32'd19,         "R5 jalr same register");
    push_reg(11, 32'd13,         "R2 addi after link");
    push_reg(12, 32'd17,         "R6 lea backward");
    push_mem(64, 32'd5,          "R3 sw positive offset");
    push_mem(62, 32'd13,         "R3 sw base plus offset");
    // Exact results of every bus transfer above rely on R9 (single driver)
    push_reg(13, 32'd0,          "R9 no stray bus write");
    drain();

    // R8: halted core holds state
    repeat (20) @(negedge clk);
    check(halted === 1'b1, "R8 halted stays high", 32'(halted), 32'd1);
    push_reg(1,  32'd5,  "R8 r1 unchanged after halt");
    push_reg(12, 32'd17, "R8 r12 unchanged after halt");
    push_mem(62, 32'd13, "R8 memory unchanged after halt");
    drain();

    // R10: unused opcodes halt after the 3 fetch cycles
    for (int op = 10; op < 16; op += 5) begin
      @(negedge clk);
      rst_n = 1'b0;
      load_word(0, enc(4'(op), 1, 0, 3));
      @(negedge clk);
      check(halted === 1'b0, "R1 halted low after reset", 32'(halted), 32'd0);
      run_until_halt(cyc);
      check(cyc == 3, "R10 unused opcode halts", 32'(cyc), 32'd3);
      push_reg(1, 32'd0, "R10 unused opcode writes nothing");
      drain();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule